// File: doc/BRIEF.md
# Shared Queue Pointer Controller

This block tracks the write (put) and read (get) positions of one circular message queue that two processors share. The local processor configures the queue through two registers. A control word holds the index of the last queue entry and a two-party reinitialisation handshake. A 32-bit register holds the address of the first entry. The block turns the two positions into entry addresses and reports when the queue is full or empty.

Either side may ask for the queue to be reinitialised, but the pointers only return to zero once both sides agree. The local side sets its own reset flag through a register write. The remote side sets a request flag through a dedicated set-only input. In the cycle after both flags are seen high, the two pointers and both flags go back to zero together. One slot is always left open, so a queue whose last index is N holds at most N messages at a time.

Top module: `shared_queue_ptr_ctrl`

## Requirements
- R1: After reset both registers read 0, both entry addresses equal 0, and empty is high. Full is also high, because a last index of 0 gives no usable slot.
- R2: In the control word (regSel = 0), bits 15:0 hold the last entry index and are read/write. Bits 29:16 always read 0 and ignore writes.
- R3: The base register (regSel = 1) is a 32-bit read/write register with a reset value of 0.
- R4: Control bit 31 is the local reset flag. Writing 1 sets it. Writing 0 leaves it unchanged. It reads back at bit 31.
- R5: Control bit 30 is the remote request flag. A pulse on remoteReqSet sets it. Local writes to bit 30 have no effect.
- R6: If only one of the two flags is set, the pointers do not move. In the cycle after both flags are high, the put pointer, the get pointer and both flags all become 0 on the same edge. The last index and the base are kept.
- R7: Each accepted put or get strobe advances its pointer by one. A pointer that equals the last index wraps to 0.
- R8: Each entry address equals base + pointer × ENTRY_BYTES, truncated to 32 bits (ENTRY_BYTES = 8 by default).
- R9: Empty is high when put equals get. Full is high when the wrapped successor of put equals get. A put while full and a get while empty are ignored.
- R10: When a reinitialisation and a put or get strobe fall in the same cycle, the reinitialisation wins and the strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Local register write strobe |
| regSel | input | 1 | Register select: 0 = control word, 1 = base |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| remoteReqSet | input | 1 | Remote side sets the request flag |
| putStrobe | input | 1 | Advance the put pointer |
| getStrobe | input | 1 | Advance the get pointer |
| putAddr | output | 32 | Address of the current put entry |
| getAddr | output | 32 | Address of the current get entry |
| queueFull | output | 1 | Queue is full |
| queueEmpty | output | 1 | Queue is empty |

## Verification
Two functions can fall in the same cycle here: the handshake reinitialisation and a pointer strobe. A put or get can also coincide with its opposite when the queue is full or empty. The bench raises the remote request while the local flag is already set. It holds a put strobe high in the very cycle where both flags are visible. It then expects both addresses back at base with both flags cleared, so the put must have been dropped. Put and get are also driven together at the full and empty limits. The expected positions from a table show which of the two strobes was accepted.

// File: rtl/sqp_pkg.sv
package sqp_pkg;

  typedef struct packed {
    logic advPut;
    logic advGet;
    logic reinit;
  } sqpStrobes_t;

  localparam int RST_FLAG_BIT = 31;
  localparam int REQ_FLAG_BIT = 30;

endpackage

// File: rtl/sqp_ctrl.sv
module sqp_ctrl
  import sqp_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              remoteReqSet,
  input  logic              putStrobe,
  input  logic              getStrobe,
  input  logic              full,
  input  logic              empty,
  output sqpStrobes_t       strobes,
  output logic [IDX_W-1:0]  lastIdx,
  output logic [DATA_W-1:0] baseAddr
);

  logic localRst;
  logic remoteReq;
  logic ctrlWr;
  logic baseWr;
  logic reinit;

  assign ctrlWr = regWrEn && !regSel;
  assign baseWr = regWrEn && regSel;
  assign reinit = localRst && remoteReq;

  // handshake flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      localRst  <= 1'b0;
      remoteReq <= 1'b0;
    end else if (reinit) begin
      localRst  <= 1'b0;
      remoteReq <= 1'b0;
    end else begin
      if (ctrlWr && regWrData[RST_FLAG_BIT]) localRst <= 1'b1;
      if (remoteReqSet) remoteReq <= 1'b1;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastIdx  <= '0;
      baseAddr <= '0;
    end else begin
      if (ctrlWr) lastIdx  <= regWrData[IDX_W-1:0];
      if (baseWr) baseAddr <= regWrData;
    end
  end

  always_comb begin
    strobes.reinit = reinit;
    strobes.advPut = putStrobe && !full && !reinit;
    strobes.advGet = getStrobe && !empty && !reinit;
  end

  always_comb begin
    regRdData = '0;
    if (regSel) begin
      regRdData = baseAddr;
    end else begin
      regRdData[IDX_W-1:0]    = lastIdx;
      regRdData[RST_FLAG_BIT] = localRst;
      regRdData[REQ_FLAG_BIT] = remoteReq;
    end
  end

  assert_rst_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    localRst && !remoteReq |=> localRst);
  assert_rst_origin_R4: assert property (@(posedge clk) disable iff (!rstN)
    !localRst && !(ctrlWr && regWrData[RST_FLAG_BIT]) |=> !localRst);
  assert_req_origin_R5: assert property (@(posedge clk) disable iff (!rstN)
    !remoteReq && !remoteReqSet |=> !remoteReq);
  assert_req_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    remoteReq && !localRst |=> remoteReq);
  assert_flags_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    localRst && remoteReq |=> !localRst && !remoteReq);
  assert_no_put_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strobes.advPut);
  assert_no_get_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !strobes.advGet);
  assert_reinit_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reinit |-> !strobes.advPut && !strobes.advGet);

endmodule

// File: rtl/sqp_datapath.sv
module sqp_datapath
  import sqp_pkg::*;
#(
  parameter int IDX_W       = 16,
  parameter int DATA_W      = 32,
  parameter int ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sqpStrobes_t       strobes,
  input  logic [IDX_W-1:0]  lastIdx,
  input  logic [DATA_W-1:0] baseAddr,
  output logic [DATA_W-1:0] putAddr,
  output logic [DATA_W-1:0] getAddr,
  output logic              full,
  output logic              empty
);

  localparam logic [DATA_W-1:0] STRIDE = DATA_W'(ENTRY_BYTES);

  logic [IDX_W-1:0] putPtr;
  logic [IDX_W-1:0] getPtr;
  logic [IDX_W-1:0] putNext;
  logic [IDX_W-1:0] getNext;

  // a pointer at or past the last index wraps to 0
  assign putNext = (putPtr >= lastIdx) ? '0 : putPtr + 1'b1;
  assign getNext = (getPtr >= lastIdx) ? '0 : getPtr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.reinit) begin
      putPtr <= '0;
      getPtr <= '0;
    end else begin
      if (strobes.advPut) putPtr <= putNext;
      if (strobes.advGet) getPtr <= getNext;
    end
  end

  assign empty   = (putPtr == getPtr);
  assign full    = (putNext == getPtr);
  assign putAddr = baseAddr + DATA_W'(putPtr) * STRIDE;
  assign getAddr = baseAddr + DATA_W'(getPtr) * STRIDE;

  assert_reinit_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reinit |=> putPtr == '0 && getPtr == '0);
  assert_put_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advPut && putPtr == lastIdx |=> putPtr == '0);
  assert_put_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advPut && putPtr < lastIdx |=> putPtr == $past(putPtr) + 1'b1);
  assert_put_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advPut && !strobes.reinit |=> $stable(putPtr));
  assert_get_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advGet && !strobes.reinit |=> $stable(getPtr));

endmodule

// File: rtl/shared_queue_ptr_ctrl.sv
module shared_queue_ptr_ctrl
  import sqp_pkg::*;
#(
  parameter int IDX_W       = 16,
  parameter int DATA_W      = 32,
  parameter int ENTRY_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              remoteReqSet,
  input  logic              putStrobe,
  input  logic              getStrobe,
  output logic [DATA_W-1:0] putAddr,
  output logic [DATA_W-1:0] getAddr,
  output logic              queueFull,
  output logic              queueEmpty
);

  sqpStrobes_t       strobes;
  logic [IDX_W-1:0]  lastIdx;
  logic [DATA_W-1:0] baseAddr;

  sqp_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .remoteReqSet(remoteReqSet),
    .putStrobe(putStrobe), .getStrobe(getStrobe), .full(queueFull),
    .empty(queueEmpty), .strobes(strobes), .lastIdx(lastIdx), .baseAddr(baseAddr)
  );

  sqp_datapath #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ENTRY_BYTES(ENTRY_BYTES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lastIdx(lastIdx),
    .baseAddr(baseAddr), .putAddr(putAddr), .getAddr(getAddr),
    .full(queueFull), .empty(queueEmpty)
  );

endmodule

// File: tb/shared_queue_ptr_ctrl_tb_top.sv
module shared_queue_ptr_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int NVEC = 11;
  // [7] put [6] get [5:4] exp put idx [3:2] exp get idx [1] full [0] empty
  localparam logic [7:0] VECS [NVEC] = '{
    8'b10_01_00_00, 8'b10_10_00_00, 8'b10_11_00_10, 8'b10_11_00_10,
    8'b01_11_01_00, 8'b11_00_10_00, 8'b01_00_11_00, 8'b01_00_00_01,
    8'b01_00_00_01, 8'b11_01_00_00, 8'b01_01_01_01
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic remoteReqSet = 1'b0;
  logic putStrobe = 1'b0;
  logic getStrobe = 1'b0;
  logic [31:0] putAddr;
  logic [31:0] getAddr;
  logic queueFull;
  logic queueEmpty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_queue_ptr_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .remoteReqSet(remoteReqSet),
    .putStrobe(putStrobe), .getStrobe(getStrobe), .putAddr(putAddr),
    .getAddr(getAddr), .queueFull(queueFull), .queueEmpty(queueEmpty)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = regRdData;
  endtask

  task automatic writeReg(input logic sel, input logic [31:0] val);
    regSel = sel; regWrData = val; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic checkPtrs(input string req, input int p, input int g);
    check(req, putAddr, BASE + 32'(p) * 8);
    check(req, getAddr, BASE + 32'(g) * 8);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(1'b0, rd); check("R1 ctrl", rd, 32'h0);
    readReg(1'b1, rd); check("R1 base", rd, 32'h0);
    check("R1 putAddr", putAddr, 32'h0);
    check("R1 empty", {31'b0, queueEmpty}, 32'h1);
    check("R1 full", {31'b0, queueFull}, 32'h1);

    // R2 reserved bits, R5 local write of request bit ignored
    writeReg(1'b0, 32'h7FFF_0003);
    readReg(1'b0, rd); check("R2/R5 ctrl readback", rd, 32'h0000_0003);
    // R3 base register
    writeReg(1'b1, BASE);
    readReg(1'b1, rd); check("R3 base readback", rd, BASE);
    checkPtrs("R8 start address", 0, 0);

    // table-driven R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      putStrobe = VECS[i][7]; getStrobe = VECS[i][6];
      tick();
      putStrobe = 1'b0; getStrobe = 1'b0;
      checkPtrs($sformatf("R7/R8 vec %0d", i), int'(VECS[i][5:4]), int'(VECS[i][3:2]));
      check($sformatf("R9 full vec %0d", i), {31'b0, queueFull}, {31'b0, VECS[i][1]});
      check($sformatf("R9 empty vec %0d", i), {31'b0, queueEmpty}, {31'b0, VECS[i][0]});
    end

    // now put=1 get=1; advance put to 2
    putStrobe = 1'b1; tick(); putStrobe = 1'b0;
    checkPtrs("R7 pre-handshake", 2, 1);

    // R4 local flag set-only, R6 alone does nothing
    writeReg(1'b0, 32'h8000_0003);
    readReg(1'b0, rd); check("R4 set", rd, 32'h8000_0003);
    writeReg(1'b0, 32'h0000_0003);
    readReg(1'b0, rd); check("R4 write 0 ignored", rd, 32'h8000_0003);
    checkPtrs("R6 local flag alone", 2, 1);

    // R5 remote request, both flags visible for one cycle
    remoteReqSet = 1'b1; tick(); remoteReqSet = 1'b0;
    readReg(1'b0, rd); check("R5 both flags", rd, 32'hC000_0003);
    checkPtrs("R6 not yet cleared", 2, 1);
    // R10 put and get in the reinit cycle are dropped
    putStrobe = 1'b1; getStrobe = 1'b1; tick(); putStrobe = 1'b0; getStrobe = 1'b0;
    checkPtrs("R10 reinit wins", 0, 0);
    readReg(1'b0, rd); check("R6 flags cleared", rd, 32'h0000_0003);
    check("R6 empty", {31'b0, queueEmpty}, 32'h1);

    // R6 request first, then local flag
    putStrobe = 1'b1; tick(); putStrobe = 1'b0;
    remoteReqSet = 1'b1; tick(); remoteReqSet = 1'b0;
    readReg(1'b0, rd); check("R5 request alone", rd, 32'h4000_0003);
    checkPtrs("R6 request alone", 1, 0);
    writeReg(1'b0, 32'h8000_0003);
    readReg(1'b0, rd); check("R6 both flags", rd, 32'hC000_0003);
    tick();
    checkPtrs("R6 reinit", 0, 0);
    readReg(1'b0, rd); check("R6 cleared", rd, 32'h0000_0003);
    readReg(1'b1, rd); check("R6 base kept", rd, BASE);

    // R8 truncation with high base
    writeReg(1'b1, 32'hFFFF_FFF8);
    putStrobe = 1'b1; tick(); putStrobe = 1'b0;
    check("R8 wrap of address", putAddr, 32'h0000_0000);
    check("R8 get address", getAddr, 32'hFFFF_FFF8);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule